// File: doc/BRIEF.md
# Cross-Domain Register Synchronization Controller

This block stands between a bus-clocked register file and a timer core that runs from its own clock. Every register belongs to one of four groups with distinct write rules: a run/command group whose changes travel to the core through a handshake, a double-buffered group (two compare values and a delay value) whose bus-side copies are moved into core-side shadows only on a transfer, a static group that is frozen while the block runs, and a plain register that is always writable. Two ready flags tell software when the run bit may change and when commands or buffered writes are accepted.

A transfer of the buffered values into the core shadows happens on enable, on an immediate command, on an end-of-cycle command that waits for the next end-of-cycle pulse from the core, or automatically when the high byte of the second compare value is written with auto-update on. Each crossing is a toggle request answered by a toggle acknowledge, both passed through flop chains.

Top module: `xsync_ctrl`

## Requirements
- R1: After reset the run bit, mode, static and plain registers, command bits and all core shadows are 0, `en_rdy` is 1 and `cmd_rdy` is 0.
- R2: The run bit (address 0, bit 0) changes only when written while `en_rdy` is 1; an accepted change drops `en_rdy` from the next bus cycle until the core acknowledges, and the core copy `core_run` then follows.
- R3: The mode field (address 0, bits 7:1) accepts writes only while the run bit is 0.
- R4: The static register (address 2, bit 0 = auto-update enable) ignores writes while the run bit is 1.
- R5: Writes to the buffered registers (address 4/5 = compare A low/high byte, 6/7 = compare B low/high byte, 8 = delay) are accepted only while `cmd_rdy` is 1, which requires the run bit at 1 and no handshake in flight.
- R6: Setting the run bit copies all buffered values into the core shadows; clearing it leaves the shadows unchanged.
- R7: Writing address 1 with bit 0 set (immediate transfer) copies the buffered values once, as soon as the request reaches the core, with no end-of-cycle pulse needed.
- R8: Writing address 1 with only bit 1 set (end-of-cycle transfer) copies the buffered values on the first `core_eoc` pulse after the request reaches the core; shadows stay unchanged before that, and an `core_eoc` pulse with no pending request changes nothing.
- R9: With auto-update on, an accepted write to address 7 launches an end-of-cycle transfer without setting command bits; a write to address 6 launches nothing.
- R10: A command written while a transfer is in flight has no effect: the command bits keep their value and no extra copy happens.
- R11: The accepted command bits read back on `cmd_pend` and clear when the core's acknowledge returns.
- R12: The plain register (address 3) takes every write regardless of run or ready state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst | input | 1 | Bus-side synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| en_rdy | output | 1 | Run bit may be changed |
| cmd_rdy | output | 1 | Commands and buffered writes accepted |
| ctl_run | output | 1 | Bus-side run bit |
| ctl_mode | output | 7 | Run-protected mode field |
| stat_cfg | output | 8 | Static configuration register |
| norm_reg | output | 8 | Plain register |
| cmd_pend | output | 2 | Command bits in flight |
| core_clk | input | 1 | Core clock |
| core_rst | input | 1 | Core-side synchronous reset, active high |
| core_eoc | input | 1 | End-of-cycle pulse from the timer core |
| core_run | output | 1 | Run bit as seen by the core |
| core_cmpa | output | 16 | Core shadow of compare A |
| core_cmpb | output | 16 | Core shadow of compare B |
| core_dly | output | 8 | Core shadow of the delay value |

## Verification
The bench drives the two clocks at unrelated periods and checks the core shadows on every core clock, demanding they hold exactly while an end-of-cycle transfer waits, so a design that copied on arrival or on a stray end-of-cycle pulse would show a shadow change too early. It writes buffered registers and the run bit while a handshake is in flight and later exposes the result through a transfer; a design that let such writes through would carry the dropped byte into the shadows or flip the run bit. It issues an immediate command behind a pending end-of-cycle one, which a design without the busy guard would turn into an early copy, and it writes the low compare byte under auto-update, which a wrongly decoded trigger would turn into a spurious transfer with the ready flags low.

// File: rtl/xsync_pkg.sv
package xsync_pkg;

    parameter int unsigned BYTE_W    = 8;
    parameter int unsigned DLY_W     = 8;
    parameter int unsigned CMP_W     = 2 * BYTE_W;
    parameter int unsigned CMP_BYTES = CMP_W / BYTE_W;
    parameter int unsigned ADDR_W    = 4;
    parameter int unsigned CMD_W     = 2;

    localparam logic [ADDR_W-1:0] A_CTL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMD  = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
    localparam logic [ADDR_W-1:0] A_NORM = 4'd3;
    localparam logic [ADDR_W-1:0] A_CAL  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CBL  = 4'd6;
    localparam logic [ADDR_W-1:0] A_DLY  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CB_LAST = ADDR_W'(A_CBL + CMP_BYTES - 1);

    // Bit positions inside the command and static registers.
    localparam int unsigned CMD_NOW_BIT  = 0;
    localparam int unsigned CMD_EOC_BIT  = 1;
    localparam int unsigned STAT_AUTO_BIT = 0;

    typedef enum logic {
        XK_NOW = 1'b0,
        XK_EOC = 1'b1
    } xfer_kind_e;

    typedef struct packed {
        logic [CMP_W-1:0] cmpa;
        logic [CMP_W-1:0] cmpb;
        logic [DLY_W-1:0] dly;
    } dbuf_t;

    function automatic logic is_byte_of(input logic [ADDR_W-1:0] addr,
                                        input logic [ADDR_W-1:0] base,
                                        input int unsigned       idx);
        return addr == ADDR_W'(base + idx);
    endfunction

endpackage

// File: rtl/xsync_toggle_sync.sv
module xsync_toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], tog_in};
            last  <= chain[STAGES-1];
        end
    end

    assign pulse = chain[STAGES-1] ^ last;
endmodule

// File: rtl/xsync_bus_regs.sv
module xsync_bus_regs
    import xsync_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              en_ack_t,
    input  logic              x_ack_t,
    output logic              en_req_t,
    output logic              x_req_t,
    output xfer_kind_e        x_kind,
    output dbuf_t             dbuf,
    output logic              run,
    output logic [BYTE_W-2:0] mode,
    output logic [BYTE_W-1:0] stat,
    output logic [BYTE_W-1:0] norm,
    output logic [CMD_W-1:0]  cmd_pend,
    output logic              en_rdy,
    output logic              cmd_rdy
);
    logic en_busy, x_busy;
    logic en_ack, x_ack;
    logic wr_ctl, wr_cmd, wr_stat, wr_norm;
    logic en_go, cmd_go, auto_go, x_go;

    xsync_toggle_sync #(.STAGES(SYNC_STAGES)) u_en_ack (
        .clk(clk), .rst(rst), .tog_in(en_ack_t), .pulse(en_ack)
    );
    xsync_toggle_sync #(.STAGES(SYNC_STAGES)) u_x_ack (
        .clk(clk), .rst(rst), .tog_in(x_ack_t), .pulse(x_ack)
    );

    assign en_rdy  = !en_busy && !x_busy;
    assign cmd_rdy = run && en_rdy;

    always_comb begin
        wr_ctl  = wr_en && (wr_addr == A_CTL);
        wr_cmd  = wr_en && (wr_addr == A_CMD);
        wr_stat = wr_en && (wr_addr == A_STAT);
        wr_norm = wr_en && (wr_addr == A_NORM);
        en_go   = wr_ctl && en_rdy && (wr_data[0] != run);
        cmd_go  = wr_cmd && cmd_rdy && (wr_data[CMD_W-1:0] != '0);
        auto_go = wr_en && (wr_addr == A_CB_LAST) && cmd_rdy && stat[STAT_AUTO_BIT];
        x_go    = cmd_go || auto_go;
    end

    // Run bit, run-protected mode field and enable handshake launch.
    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            mode     <= '0;
            en_req_t <= 1'b0;
            en_busy  <= 1'b0;
        end else begin
            if (wr_ctl && !run) mode <= wr_data[BYTE_W-1:1];
            if (en_go) begin
                run      <= wr_data[0];
                en_req_t <= ~en_req_t;
                en_busy  <= 1'b1;
            end else if (en_ack) begin
                en_busy  <= 1'b0;
            end
        end
    end

    // Static and plain registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            norm <= '0;
        end else begin
            if (wr_stat && !run) stat <= wr_data;
            if (wr_norm)         norm <= wr_data;
        end
    end

    // Double-buffered bus-side copies, byte addressed.
    always_ff @(posedge clk) begin
        if (rst) begin
            dbuf <= '0;
        end else if (wr_en && cmd_rdy) begin
            for (int b = 0; b < CMP_BYTES; b++) begin
                if (is_byte_of(wr_addr, A_CAL, b)) dbuf.cmpa[b*BYTE_W +: BYTE_W] <= wr_data;
                if (is_byte_of(wr_addr, A_CBL, b)) dbuf.cmpb[b*BYTE_W +: BYTE_W] <= wr_data;
            end
            if (wr_addr == A_DLY) dbuf.dly <= DLY_W'(wr_data);
        end
    end

    // Transfer request launch and strobe command bits.
    always_ff @(posedge clk) begin
        if (rst) begin
            x_req_t  <= 1'b0;
            x_busy   <= 1'b0;
            x_kind   <= XK_NOW;
            cmd_pend <= '0;
        end else if (x_go) begin
            x_req_t  <= ~x_req_t;
            x_busy   <= 1'b1;
            x_kind   <= (cmd_go && wr_data[CMD_NOW_BIT]) ? XK_NOW : XK_EOC;
            cmd_pend <= cmd_go ? wr_data[CMD_W-1:0] : '0;
        end else if (x_ack) begin
            x_busy   <= 1'b0;
            cmd_pend <= '0;
        end
    end
endmodule

// File: rtl/xsync_core_shadow.sv
module xsync_core_shadow
    import xsync_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       eoc,
    input  logic       en_req_t,
    input  logic       x_req_t,
    input  logic       run_bus,
    input  xfer_kind_e x_kind,
    input  dbuf_t      dbuf_bus,
    output logic       en_ack_t,
    output logic       x_ack_t,
    output logic       core_run,
    output dbuf_t      shadow,
    output logic       pend
);
    logic en_pulse, x_pulse;

    xsync_toggle_sync #(.STAGES(SYNC_STAGES)) u_en_req (
        .clk(clk), .rst(rst), .tog_in(en_req_t), .pulse(en_pulse)
    );
    xsync_toggle_sync #(.STAGES(SYNC_STAGES)) u_x_req (
        .clk(clk), .rst(rst), .tog_in(x_req_t), .pulse(x_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            core_run <= 1'b0;
            shadow   <= '0;
            pend     <= 1'b0;
            en_ack_t <= 1'b0;
            x_ack_t  <= 1'b0;
        end else begin
            if (en_pulse) begin
                core_run <= run_bus;
                if (run_bus) shadow <= dbuf_bus;
                en_ack_t <= ~en_ack_t;
            end
            if (x_pulse) begin
                if (x_kind == XK_NOW) begin
                    shadow  <= dbuf_bus;
                    x_ack_t <= ~x_ack_t;
                end else begin
                    pend    <= 1'b1;
                end
            end else if (pend && eoc) begin
                shadow  <= dbuf_bus;
                pend    <= 1'b0;
                x_ack_t <= ~x_ack_t;
            end
        end
    end
endmodule

// File: rtl/xsync_ctrl.sv
module xsync_ctrl
    import xsync_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              en_rdy,
    output logic              cmd_rdy,
    output logic              ctl_run,
    output logic [BYTE_W-2:0] ctl_mode,
    output logic [BYTE_W-1:0] stat_cfg,
    output logic [BYTE_W-1:0] norm_reg,
    output logic [CMD_W-1:0]  cmd_pend,
    input  logic              core_clk,
    input  logic              core_rst,
    input  logic              core_eoc,
    output logic              core_run,
    output logic [CMP_W-1:0]  core_cmpa,
    output logic [CMP_W-1:0]  core_cmpb,
    output logic [DLY_W-1:0]  core_dly
);
    logic       en_req_t, x_req_t, en_ack_t, x_ack_t;
    logic       core_pend;
    xfer_kind_e x_kind;
    dbuf_t      bus_dbuf;
    dbuf_t      core_shadow;

    xsync_bus_regs #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk(bus_clk), .rst(bus_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en_ack_t(en_ack_t), .x_ack_t(x_ack_t),
        .en_req_t(en_req_t), .x_req_t(x_req_t), .x_kind(x_kind),
        .dbuf(bus_dbuf), .run(ctl_run), .mode(ctl_mode), .stat(stat_cfg),
        .norm(norm_reg), .cmd_pend(cmd_pend),
        .en_rdy(en_rdy), .cmd_rdy(cmd_rdy)
    );

    xsync_core_shadow #(.SYNC_STAGES(SYNC_STAGES)) u_core (
        .clk(core_clk), .rst(core_rst), .eoc(core_eoc),
        .en_req_t(en_req_t), .x_req_t(x_req_t),
        .run_bus(ctl_run), .x_kind(x_kind), .dbuf_bus(bus_dbuf),
        .en_ack_t(en_ack_t), .x_ack_t(x_ack_t),
        .core_run(core_run), .shadow(core_shadow), .pend(core_pend)
    );

    assign core_cmpa = core_shadow.cmpa;
    assign core_cmpb = core_shadow.cmpb;
    assign core_dly  = core_shadow.dly;
endmodule

// File: rtl/xsync_ctrl_chk.sv
module xsync_ctrl_chk
    import xsync_pkg::*;
(
    input logic              bus_clk,
    input logic              bus_rst,
    input logic              core_clk,
    input logic              core_rst,
    input logic              core_eoc,
    input logic              en_rdy,
    input logic              cmd_rdy,
    input logic              ctl_run,
    input logic [BYTE_W-2:0] ctl_mode,
    input logic [BYTE_W-1:0] stat_cfg,
    input logic [CMD_W-1:0]  cmd_pend,
    input dbuf_t             bus_dbuf,
    input dbuf_t             core_shadow,
    input logic              core_pend
);
    assert_run_gate_R2: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !$stable(ctl_run) |-> $past(en_rdy));

    assert_mode_lock_R3: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !$stable(ctl_mode) |-> !$past(ctl_run));

    assert_static_lock_R4: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !$stable(stat_cfg) |-> !$past(ctl_run));

    assert_dbuf_gate_R5: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !$stable(bus_dbuf) |-> $past(cmd_rdy));

    assert_eoc_copy_R8: assert property (@(posedge core_clk) disable iff (core_rst)
        ($past(core_pend) && !$stable(core_shadow)) |-> $past(core_eoc));

    assert_strobe_clear_R11: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $rose(en_rdy) |-> (cmd_pend == '0));
endmodule

bind xsync_ctrl xsync_ctrl_chk u_chk (
    .bus_clk(bus_clk), .bus_rst(bus_rst),
    .core_clk(core_clk), .core_rst(core_rst), .core_eoc(core_eoc),
    .en_rdy(en_rdy), .cmd_rdy(cmd_rdy), .ctl_run(ctl_run),
    .ctl_mode(ctl_mode), .stat_cfg(stat_cfg), .cmd_pend(cmd_pend),
    .bus_dbuf(bus_dbuf), .core_shadow(core_shadow), .core_pend(core_pend)
);

// File: tb/sim_xsync_ctrl.sv
`timescale 1ns/1ps
module sim_xsync_ctrl;
    import xsync_pkg::*;

    logic bus_clk = 1'b0, core_clk = 1'b0;
    always #4 bus_clk = ~bus_clk;
    always #5.65 core_clk = ~core_clk;

    logic bus_rst = 1'b1, core_rst = 1'b1;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic core_eoc = 1'b0;
    logic en_rdy, cmd_rdy, ctl_run, core_run;
    logic [6:0] ctl_mode;
    logic [7:0] stat_cfg, norm_reg, core_dly;
    logic [1:0] cmd_pend;
    logic [15:0] core_cmpa, core_cmpb;

    xsync_ctrl u0 (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en_rdy(en_rdy), .cmd_rdy(cmd_rdy), .ctl_run(ctl_run),
        .ctl_mode(ctl_mode), .stat_cfg(stat_cfg), .norm_reg(norm_reg),
        .cmd_pend(cmd_pend), .core_clk(core_clk), .core_rst(core_rst),
        .core_eoc(core_eoc), .core_run(core_run), .core_cmpa(core_cmpa),
        .core_cmpb(core_cmpb), .core_dly(core_dly)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic checking = 1'b0;

    // Reference model state.
    logic       m_run = 0, m_busy = 0, m_window = 0, m_eoc_wait = 0;
    logic [6:0] m_mode = 0;
    logic [7:0] m_stat = 0, m_norm = 0;
    dbuf_t      m_buf = '0, m_core = '0, m_new = '0;

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic dbuf_t got_shadow();
        dbuf_t g;
        g.cmpa = core_cmpa; g.cmpb = core_cmpb; g.dly = core_dly;
        return g;
    endfunction

    // Bus-side comparison every bus clock.
    always @(negedge bus_clk) begin
        if (checking) begin
            chk("R2 run", ctl_run, m_run);
            chk("R3 mode", ctl_mode, m_mode);
            chk("R4 static", stat_cfg, m_stat);
            chk("R12 plain", norm_reg, m_norm);
            if (!m_busy) begin
                chk("R2 en_rdy idle", en_rdy, 1);
                chk("R5 cmd_rdy idle", cmd_rdy, m_run);
                chk("R11 cmd_pend idle", cmd_pend, 0);
            end
        end
    end

    // Core shadow comparison every core clock.
    always @(negedge core_clk) begin
        if (checking) begin
            n_chk++;
            if (!((got_shadow() == m_core) || (m_window && got_shadow() == m_new))) begin
                n_bad++;
                $display("FAIL R8 shadow actual=%0h expected=%0h at %0t",
                         got_shadow(), m_core, $time);
            end
        end
    end

    always @(posedge bus_clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic bwr(input logic [3:0] a, input logic [7:0] d);
        logic rdy, crdy, old_run;
        @(posedge bus_clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        rdy = !m_busy; crdy = m_run && !m_busy; old_run = m_run;
        @(posedge bus_clk);
        case (a)
            4'd0: begin
                if (!old_run) m_mode = d[7:1];
                if (rdy && d[0] != old_run) begin
                    m_run = d[0]; m_busy = 1;
                    if (d[0]) begin m_new = m_buf; m_window = 1; end
                end
            end
            4'd1: if (crdy && d[1:0] != 0) begin
                m_busy = 1; m_new = m_buf;
                if (d[0]) m_window = 1; else m_eoc_wait = 1;
            end
            4'd2: if (!old_run) m_stat = d;
            4'd3: m_norm = d;
            4'd4: if (crdy) m_buf.cmpa[7:0] = d;
            4'd5: if (crdy) m_buf.cmpa[15:8] = d;
            4'd6: if (crdy) m_buf.cmpb[7:0] = d;
            4'd7: if (crdy) begin
                m_buf.cmpb[15:8] = d;
                if (m_stat[0]) begin m_busy = 1; m_new = m_buf; m_eoc_wait = 1; end
            end
            4'd8: if (crdy) m_buf.dly = d;
            default: ;
        endcase
        #1 wr_en = 0;
    endtask

    task automatic wait_ready();
        @(negedge bus_clk);
        while (!en_rdy) @(negedge bus_clk);
        if (m_window) m_core = m_new;
        m_window = 0;
        m_busy = 0;
    endtask

    task automatic pulse_eoc();
        repeat (12) @(posedge core_clk);
        #1 core_eoc = 1;
        @(posedge core_clk);
        if (m_eoc_wait) begin m_core = m_new; m_eoc_wait = 0; end
        #1 core_eoc = 0;
    endtask

    initial begin
        repeat (6) @(posedge bus_clk);
        #1 bus_rst = 0; core_rst = 0;
        @(negedge bus_clk);
        // R1: reset state
        chk("R1 en_rdy", en_rdy, 1);
        chk("R1 cmd_rdy", cmd_rdy, 0);
        chk("R1 run", ctl_run, 0);
        chk("R1 cmd_pend", cmd_pend, 0);
        chk("R1 core_run", core_run, 0);
        chk("R1 shadow", got_shadow(), 0);
        checking = 1;

        bwr(4'd3, 8'hA5);                 // R12
        chk("R12 plain write", norm_reg, 8'hA5);
        bwr(4'd4, 8'h11);                 // R5: dropped while disabled
        bwr(4'd0, 8'hB4);                 // R3: mode 5A, run stays 0
        bwr(4'd2, 8'h80);                 // R4: static accepted while stopped
        chk("R3 mode while stopped", ctl_mode, 7'h5A);
        chk("R4 static while stopped", stat_cfg, 8'h80);

        bwr(4'd0, 8'hB5);                 // R2 / R6: enable
        chk("R2 en_rdy drops", en_rdy, 0);
        wait_ready();
        chk("R6 core_run", core_run, 1);
        chk("R5 dropped write absent", core_cmpa, 16'h0000);

        bwr(4'd0, 8'h03);                 // R3: mode locked
        chk("R3 mode locked", ctl_mode, 7'h5A);
        bwr(4'd2, 8'h01);                 // R4: static locked
        chk("R4 static locked", stat_cfg, 8'h80);

        bwr(4'd4, 8'h34); bwr(4'd5, 8'h12);
        bwr(4'd6, 8'h78); bwr(4'd7, 8'h56);   // auto off: no transfer (R9)
        bwr(4'd8, 8'h9A);
        chk("R9 no auto when off", cmd_rdy, 1);

        bwr(4'd1, 8'h01);                 // R7 immediate
        chk("R11 cmd bits", cmd_pend, 2'b01);
        chk("R5 cmd_rdy busy", cmd_rdy, 0);
        bwr(4'd4, 8'hFF);                 // R5: dropped while busy
        wait_ready();
        chk("R7 cmpa", core_cmpa, 16'h1234);
        chk("R7 cmpb", core_cmpb, 16'h5678);
        chk("R7 dly", core_dly, 8'h9A);
        chk("R11 cleared", cmd_pend, 0);

        bwr(4'd6, 8'hAA);
        bwr(4'd1, 8'h02);                 // R8 end-of-cycle
        bwr(4'd1, 8'h01);                 // R10: ignored while busy
        chk("R10 cmd bits kept", cmd_pend, 2'b10);
        pulse_eoc();
        wait_ready();
        chk("R8 cmpb after eoc", core_cmpb, 16'h56AA);
        chk("R10 cmpa unchanged", core_cmpa, 16'h1234);

        bwr(4'd8, 8'h77);                 // R8: stray eoc, nothing pending
        pulse_eoc();
        repeat (4) @(negedge core_clk);
        chk("R8 stray eoc", core_dly, 8'h9A);

        bwr(4'd0, 8'hB4);                 // R6: disable keeps shadows
        wait_ready();
        chk("R2 core_run off", core_run, 0);
        chk("R6 disable keeps", core_dly, 8'h9A);
        bwr(4'd2, 8'h81);                 // auto on
        bwr(4'd0, 8'hB5);
        bwr(4'd0, 8'hB4);                 // R2: ignored while not ready
        chk("R2 run held", ctl_run, 1);
        wait_ready();
        chk("R6 enable copy", core_dly, 8'h77);

        bwr(4'd6, 8'h01);                 // R9: low byte, no trigger
        chk("R9 low byte", cmd_rdy, 1);
        bwr(4'd7, 8'h02);                 // R9: high byte triggers
        chk("R9 busy", cmd_rdy, 0);
        chk("R9 no cmd bits", cmd_pend, 0);
        pulse_eoc();
        wait_ready();
        chk("R9 auto copy", core_cmpb, 16'h0201);

        repeat (10) @(negedge bus_clk);
        checking = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule